// File: doc/BRIEF.md
# Alarm Indication Signal Detector

This block watches a received line bit stream and decides whether the far end is sending an alarm indication signal, which appears on the line as an unbroken run of ones. It splits the accepted bits into fixed-length, non-overlapping blocks. It counts the zeros in each block and compares that count against a threshold when the block ends. The result sets or clears a single status bit.

Three criteria are available. Two serve 2.048 Mbit/s links and use 512-bit blocks with a threshold of 3 zeros. One of these needs two consecutive blocks to agree before the status moves. The other acts on a single block. The third criterion serves 1.544 Mbit/s links and uses 8192-bit blocks with a threshold of 9 zeros. A bit is taken only in cycles where the bit enable is high, so the block can run from a fast system clock alongside a recovered line clock.

Top module: `ais_detector`

## Requirements
- R1: After a synchronous active-low reset, `ais_out` is 0 and no partial block or earlier block result is kept.
- R2: In a cycle where `bit_en` is 0, `bit_in` is ignored. The bit is neither counted as a zero nor as a block position.
- R3: With `t1_mode`=0 and `e1_single`=0 (paired rule), `ais_out` becomes 1 when two consecutive 512-bit blocks each hold fewer than 3 zeros. It rises in the cycle after the edge that accepts the last bit of the second block.
- R4: In the paired rule, `ais_out` becomes 0 when two consecutive 512-bit blocks each hold 3 or more zeros.
- R5: In the paired rule, `ais_out` keeps its value when the two most recent blocks disagree, and also after the first block that follows a reset or mode change.
- R6: With `t1_mode`=0 and `e1_single`=1, each 512-bit block alone decides the status: fewer than 3 zeros sets `ais_out`, and 3 or more clears it.
- R7: With `t1_mode`=1, whatever the value of `e1_single`, each 8192-bit block decides the status: fewer than 9 zeros sets `ais_out`, and 9 or more clears it.
- R8: Blocks do not overlap. `ais_out` changes only at a block end, a mode change or a reset.
- R9: When the decoded mode changes, the bit offered in that cycle is discarded. The partial block and the stored previous result are cleared, and `ais_out` is 0 from the next cycle.
- R10: The per-block zero count saturates at the threshold of the active mode, so a block made entirely of zeros still clears the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | High in cycles that carry a valid received bit |
| bit_in | input | 1 | Received data bit |
| t1_mode | input | 1 | 1 selects the 8192-bit / 9-zero criterion |
| e1_single | input | 1 | When `t1_mode`=0, 1 selects the single-block rule and 0 the paired rule |
| ais_out | output | 1 | Alarm indication status |

## Verification
The in-line assertions check several rules on every cycle: the zero count never passes its threshold, the bit position stays inside the block and freezes when no bit is offered, the status moves only at a block end or a restart, a restart forces the status low, and a paired-rule rise is always preceded by a stored low-zero block. The actual set and clear decisions can only be shown by the bench scenarios. These include exact zero counts just under and at each threshold, blocks that disagree, idle gaps carrying stray zeros, and mode changes in the middle of a block. In all of them a behavioural model predicts the status on every clock.

// File: rtl/ais_pkg.sv
// Package: shared mode encoding and criterion constants for the
// alarm indication signal detector. Assumes one status per lane.
package ais_pkg;

    typedef enum logic [1:0] {
        AIS_E1_PAIR = 2'd0,   // two consecutive 512-bit blocks must agree
        AIS_E1_ONE  = 2'd1,   // one 512-bit block decides
        AIS_T1_LONG = 2'd2    // one 8192-bit block decides
    } ais_mode_e;

    // Decode the two select pins into a criterion.
    function automatic ais_mode_e ais_decode(input logic t1_sel, input logic one_sel);
        if (t1_sel)
            return AIS_T1_LONG;
        else if (one_sel)
            return AIS_E1_ONE;
        else
            return AIS_E1_PAIR;
    endfunction

endpackage

// File: rtl/ais_mode_track.sv
// Module: decodes the criterion selects and flags a restart when the
// decoded criterion differs from the one in force on the last cycle.
// Assumes selects are synchronous to clk.
module ais_mode_track
    import ais_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      t1_sel,
    input  logic      one_sel,
    output ais_mode_e mode,
    output logic      restart
);

    ais_mode_e mode_now;
    ais_mode_e mode_q;

    // Combinational decode of the current selects.
    always_comb mode_now = ais_decode(t1_sel, one_sel);

    // Remember the criterion seen on the previous cycle.
    always_ff @(posedge clk) begin
        mode_q <= mode_now;
    end

    // A restart is any cycle whose decoded criterion differs from the last.
    always_comb begin
        mode    = mode_now;
        restart = rst_n && (mode_now != mode_q);
    end

endmodule

// File: rtl/ais_block_count.sv
// Module: splits accepted bits into non-overlapping blocks and counts
// zeros per block with a saturating counter. blk_end pulses on the
// cycle whose accepted bit completes a block; blk_low then says whether
// that block held fewer zeros than the threshold. Assumes restart and
// reset both clear the partial block.
module ais_block_count
    import ais_pkg::*;
#(
    parameter int SHORT_LEN = 512,
    parameter int LONG_LEN  = 8192,
    parameter int SHORT_THR = 3,
    parameter int LONG_THR  = 9
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  ais_mode_e mode,
    input  logic      bit_en,
    input  logic      bit_in,
    output logic      blk_end,
    output logic      blk_low
);

    localparam int MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
    localparam int MAX_THR = (LONG_THR > SHORT_THR) ? LONG_THR : SHORT_THR;
    localparam int CW      = $clog2(MAX_LEN);
    localparam int ZW      = $clog2(MAX_THR + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);
    localparam logic [ZW-1:0] SHORT_Z    = ZW'(SHORT_THR);
    localparam logic [ZW-1:0] LONG_Z     = ZW'(LONG_THR);

    logic [CW-1:0] pos_q;
    logic [ZW-1:0] zeros_q;
    logic [CW-1:0] last_pos;
    logic [ZW-1:0] thr;
    logic [ZW-1:0] zeros_nx;
    logic          take;

    // Pick block length and zero threshold for the active criterion.
    always_comb begin
        if (mode == AIS_T1_LONG) begin
            last_pos = LONG_LAST;
            thr      = LONG_Z;
        end else begin
            last_pos = SHORT_LAST;
            thr      = SHORT_Z;
        end
    end

    // Saturating zero count including the bit offered this cycle.
    always_comb begin
        take     = bit_en && !restart;
        zeros_nx = zeros_q;
        if (take && !bit_in && (zeros_q < thr))
            zeros_nx = zeros_q + 1'b1;
        blk_end  = take && (pos_q == last_pos);
        blk_low  = (zeros_nx < thr);
    end

    // Advance the bit position and zero count; wrap at a block end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q   <= '0;
            zeros_q <= '0;
        end else if (blk_end) begin
            pos_q   <= '0;
            zeros_q <= '0;
        end else if (take) begin
            pos_q   <= pos_q + 1'b1;
            zeros_q <= zeros_nx;
        end
    end

    // R10: zero count never passes the active threshold.
    p_zero_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (zeros_q <= thr));

    // R8: the bit position stays inside the active block.
    p_pos_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (pos_q <= last_pos));

    // R2: with no bit offered the position and count freeze.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !restart) |=> ($stable(pos_q) && $stable(zeros_q)));

endmodule

// File: rtl/ais_status.sv
// Module: turns block results into the alarm status. In the paired rule
// it stores the previous block's result and moves only when both agree;
// otherwise each block decides alone. Assumes blk_end is a one-cycle pulse.
module ais_status
    import ais_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  ais_mode_e mode,
    input  logic      blk_end,
    input  logic      blk_low,
    output logic      ais
);

    logic ais_q;
    logic prev_valid;
    logic prev_low;
    logic ais_nx;

    // Decide the next status from the finished block.
    always_comb begin
        ais_nx = ais_q;
        if (blk_end) begin
            if (mode == AIS_E1_PAIR) begin
                if (prev_valid && prev_low && blk_low)
                    ais_nx = 1'b1;
                else if (prev_valid && !prev_low && !blk_low)
                    ais_nx = 1'b0;
            end else begin
                ais_nx = blk_low;
            end
        end
    end

    // Hold the status and the previous block's result.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ais_q      <= 1'b0;
            prev_valid <= 1'b0;
            prev_low   <= 1'b0;
        end else if (blk_end) begin
            ais_q      <= ais_nx;
            prev_valid <= 1'b1;
            prev_low   <= blk_low;
        end
    end

    assign ais = ais_q;

    // R8: status moves only after a block end or a restart.
    p_change_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ais_q) |-> $past(blk_end || restart));

    // R9: a restart forces the status low on the next cycle.
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ais_q);

    // R3: a paired-rule rise needs a stored low-zero block.
    p_pair_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_end && !restart && mode == AIS_E1_PAIR && !ais_q && blk_low) |=>
        (ais_q == $past(prev_valid && prev_low)));

endmodule

// File: rtl/ais_detector.sv
// Module: top of the alarm indication signal detector. Ties the mode
// tracker, block counter and status stage together. Assumes all inputs
// are synchronous to clk.
module ais_detector
    import ais_pkg::*;
#(
    parameter int SHORT_LEN = 512,
    parameter int LONG_LEN  = 8192,
    parameter int SHORT_THR = 3,
    parameter int LONG_THR  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    input  logic t1_mode,
    input  logic e1_single,
    output logic ais_out
);

    ais_mode_e mode;
    logic      restart;
    logic      blk_end;
    logic      blk_low;

    ais_mode_track u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .t1_sel  (t1_mode),
        .one_sel (e1_single),
        .mode    (mode),
        .restart (restart)
    );

    ais_block_count #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .SHORT_THR (SHORT_THR),
        .LONG_THR  (LONG_THR)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .mode    (mode),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .blk_end (blk_end),
        .blk_low (blk_low)
    );

    ais_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .mode    (mode),
        .blk_end (blk_end),
        .blk_low (blk_low),
        .ais     (ais_out)
    );

    // R1: status is low on the cycle after a reset.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !ais_out);

endmodule

// File: tb/tb_ais_detector.sv
// Bench: behavioural reference model compared with ais_out on every clock.
module tb_ais_detector;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b1;
    logic t1_mode = 1'b0;
    logic e1_single = 1'b0;
    logic ais_out;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // model state
    int m_mode = 0;
    int m_bits = 0;
    int m_zeros = 0;
    int m_prev = -1;
    int m_stat = 0;

    ais_detector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .t1_mode   (t1_mode),
        .e1_single (e1_single),
        .ais_out   (ais_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int mode_code();
        return t1_mode ? 2 : (e1_single ? 1 : 0);
    endfunction

    // Reference update for the edge that follows the current inputs.
    task automatic model_edge();
        int len;
        int thr;
        bit low;
        if (!rst_n || mode_code() != m_mode) begin
            m_mode = mode_code();
            m_bits = 0; m_zeros = 0; m_prev = -1; m_stat = 0;
        end else if (bit_en) begin
            len = (m_mode == 2) ? 8192 : 512;
            thr = (m_mode == 2) ? 9 : 3;
            m_bits++;
            if (!bit_in) m_zeros++;
            if (m_bits == len) begin
                low = (m_zeros < thr);
                if (m_mode == 0) begin
                    if (m_prev == 1 && low) m_stat = 1;
                    else if (m_prev == 0 && !low) m_stat = 0;
                    m_prev = low ? 1 : 0;
                end else begin
                    m_stat = low ? 1 : 0;
                end
                m_bits = 0; m_zeros = 0;
            end
        end
    endtask

    // Compare the DUT with the model at a falling edge.
    task automatic compare();
        n_vec++;
        if (ais_out !== m_stat[0]) begin
            n_bad++;
            $display("FAIL %s: ais_out=%0b expected %0d at cycle %0d", cur_req, ais_out, m_stat, cycles);
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(input logic en, input logic b);
        bit_en = en;
        bit_in = b;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    // Named check against a value taken from the requirements.
    task automatic expect_ais(input string req, input logic val);
        n_vec++;
        if (ais_out !== val) begin
            n_bad++;
            $display("FAIL %s: ais_out=%0b expected %0b", req, ais_out, val);
        end
    endtask

    // Send a block of len accepted bits holding nz zeros; idle cycles
    // carrying a zero are inserted every 97 bits (must be ignored).
    task automatic send_block(input int len, input int nz);
        for (int i = 0; i < len; i++) begin
            if (i % 97 == 50) step(1'b0, 1'b0);
            step(1'b1, (i % 17 == 3 && i / 17 < nz) ? 1'b0 : 1'b1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        do_reset();
        expect_ais("R1", 1'b0);

        // Paired rule: first low block alone holds (R5), second sets (R3).
        cur_req = "R5";
        send_block(512, 0);
        expect_ais("R5", 1'b0);
        cur_req = "R3";
        send_block(512, 2);
        expect_ais("R3", 1'b1);
        // Disagreeing blocks keep the alarm (R5).
        cur_req = "R5";
        send_block(512, 3);
        expect_ais("R5", 1'b1);
        send_block(512, 1);
        expect_ais("R5", 1'b1);
        // Two blocks at threshold clear (R4); all-zero block exercises R10.
        cur_req = "R4";
        send_block(512, 3);
        expect_ais("R4", 1'b1);
        cur_req = "R10";
        for (int i = 0; i < 512; i++) step(1'b1, 1'b0);
        expect_ais("R10", 1'b0);

        // Long idle run full of zeros is ignored (R2).
        cur_req = "R2";
        send_block(512, 0);
        for (int i = 0; i < 600; i++) step(1'b0, 1'b0);
        send_block(512, 0);
        expect_ais("R2", 1'b1);

        // Reset mid-block clears everything (R1).
        cur_req = "R1";
        send_block(200, 0);
        do_reset();
        expect_ais("R1", 1'b0);

        // Mode change mid-block: bit discarded, state cleared (R9).
        cur_req = "R9";
        send_block(300, 0);
        e1_single = 1'b1;
        step(1'b1, 1'b1);
        expect_ais("R9", 1'b0);
        for (int i = 0; i < 511; i++) step(1'b1, 1'b1);
        expect_ais("R9", 1'b0);
        cur_req = "R6";
        step(1'b1, 1'b1);
        expect_ais("R6", 1'b1);
        send_block(512, 3);
        expect_ais("R6", 1'b0);
        send_block(512, 2);
        expect_ais("R6", 1'b1);

        // Switch from alarm to long criterion forces status low (R9).
        cur_req = "R9";
        t1_mode = 1'b1;
        step(1'b1, 1'b1);
        expect_ais("R9", 1'b0);
        cur_req = "R7";
        send_block(8192, 8);
        expect_ais("R7", 1'b1);
        // e1_single changes under t1_mode: not a mode change (R7).
        e1_single = 1'b0;
        send_block(8192, 9);
        expect_ais("R7", 1'b0);
        send_block(8192, 0);
        expect_ais("R7", 1'b1);
        // Partial block does not move the status (R8).
        cur_req = "R8";
        send_block(4000, 50);
        expect_ais("R8", 1'b1);
        send_block(4192, 0);
        expect_ais("R8", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule